// File: doc/BRIEF.md
# Trigger-Gated Pipeline Buffer Manager

The block records one data word on every clock into a circular pipeline memory, so that the recent input history stays available for a fixed time. A first-level accept strobe picks a window out of that history and copies it into one of four capture buffers. The window starts a programmable number of cycles before the strobe and has a programmable length. A second-level accept strobe releases the oldest filled buffer, which becomes free for allocation on the next clock. A simple read port drains any selected buffer word by word.

Capture buffers are handed out in rotation. Copies are queued, so strobes on consecutive clocks are all served. A strobe that finds no free buffer only increments an overflow counter. A buffer that has never been filled returns a fixed test pattern, so the readout path can be exercised without input. A separate test memory, as deep as the pipeline, can replace the live input.

Top module: `trig_buf_mgr`

## Requirements
- R1: On each clock the pipeline stores `din_i` at a write pointer that starts at 0 after reset and advances by one per clock, modulo 512. On a first-level accept sampled on the edge that writes edge-index X, word k of the captured window is the word written at edge X - `pipe_lat_i` + k. Valid `pipe_lat_i` is 1 to 511.
- R2: The window length is latched from `win_len_i` at the accept. A value of 1 to 64 is used as given, and 0 or a value above 64 gives 64. A drained buffer yields exactly that many words.
- R3: Buffers are allocated in the order 0, 1, 2, 3, 0, and so on. With no copy queued ahead, `buf_full_o[b]` is low for len-1 cycles after the accept edge and rises on the len-th following edge.
- R4: Accepts on consecutive clocks each receive their own buffer, and each buffer gets its own correct window.
- R5: A second-level accept releases the oldest full buffer in allocation order. On the next cycle `rel_valid_o` is 1, `rel_buf_o` holds the index, `buf_free_o` for that buffer is 1 and its `buf_full_o` bit is 0. If the oldest allocated buffer is not full, or none is allocated, the strobe is ignored and `rel_valid_o` stays 0.
- R6: A first-level accept on the clock right after a release can claim the buffer just freed, with no overflow.
- R7: A first-level accept that finds the next buffer in rotation occupied increments `ovf_cnt_o` by one, saturating at 255. It changes no buffer contents and no allocation.
- R8: A buffer that has not been allocated since reset reads back 64 words, word a of buffer b being 0xD000 | (b << 8) | a.
- R9: Words written through `test_we_i` go into a 512-word test memory. While `src_sel_i` is 1 the pipeline stores the test word at the write-pointer address instead of `din_i`.
- R10: `rd_start_i` selects buffer `rd_sel_i` and sets the read index to 0. `rd_data_o` shows the word at the index, and each `rd_en_i` advances the index. `rd_empty_o` is 1 once the index reaches the buffer length, and also before the first start. `rd_en_i` while empty is ignored.
- R11: After reset all buffers are free, `buf_full_o` is 0, `ovf_cnt_o` is 0, `rel_valid_o` is 0 and `rd_empty_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| din_i | input | 16 | Live input word, stored every clock |
| src_sel_i | input | 1 | 1 selects test memory as pipeline source |
| test_we_i | input | 1 | Test memory write enable |
| test_addr_i | input | 9 | Test memory write address |
| test_wdata_i | input | 16 | Test memory write data |
| pipe_lat_i | input | 9 | Window start offset into history, in clocks |
| win_len_i | input | 7 | Window length in words |
| lvl1_acc_i | input | 1 | First-level accept strobe |
| lvl2_acc_i | input | 1 | Second-level accept strobe |
| rd_sel_i | input | 2 | Buffer to drain |
| rd_start_i | input | 1 | Restart read at index 0 of `rd_sel_i` |
| rd_en_i | input | 1 | Advance read index |
| rd_data_o | output | 16 | Word at current read index, 0 when empty |
| rd_empty_o | output | 1 | Read index at buffer length |
| buf_full_o | output | 4 | Per-buffer copy complete |
| buf_free_o | output | 4 | Per-buffer free for allocation |
| rel_valid_o | output | 1 | Release happened on last edge |
| rel_buf_o | output | 2 | Index of released buffer |
| ovf_cnt_o | output | 8 | Saturating count of dropped accepts |

## Verification
A wrong allocation or release pointer shows up one cycle after the strobe, as a wrong `rel_buf_o`, a missing `rel_valid_o` or a flag raised on the wrong buffer. A wrong copy counter or start address is only visible later, at the first drained word, as a value offset from the edge index it should match. The offset reveals whether the latency, the length or the wrap is at fault. A buffer that is never marked full, or an accept that is dropped by mistake, shows within one window length: the full flag fails to rise or `ovf_cnt_o` moves when it should not.

// File: rtl/tbm_pkg.sv
`timescale 1ns/1ps
package tbm_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_ARMED = 2'd1,
    SLOT_FULL  = 2'd2
  } slot_state_e;

  // power-up readback pattern of an untouched buffer
  function automatic logic [31:0] dflt_word(input logic [31:0] slot, input logic [31:0] addr);
    return 32'h0000_D000 | (slot << 8) | addr;
  endfunction
endpackage

// File: rtl/tbm_pipe.sv
`timescale 1ns/1ps
module tbm_pipe #(
  parameter int DATA_W     = 16,
  parameter int PIPE_DEPTH = 512,
  localparam int PAW       = $clog2(PIPE_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              src_sel_i,
  input  logic              test_we_i,
  input  logic [PAW-1:0]    test_addr_i,
  input  logic [DATA_W-1:0] test_wdata_i,
  input  logic [PAW-1:0]    rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PAW-1:0]    wr_ptr_o
);
  logic [DATA_W-1:0] pipe_mem [PIPE_DEPTH];
  logic [DATA_W-1:0] test_mem [PIPE_DEPTH];
  logic [PAW-1:0]    wr_ptr_q;
  logic [DATA_W-1:0] wr_word;

  assign wr_word = src_sel_i ? test_mem[wr_ptr_q] : din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_q + PAW'(1);
  end

  always_ff @(posedge clk_i) begin
    pipe_mem[wr_ptr_q] <= wr_word;
  end

  always_ff @(posedge clk_i) begin
    if (test_we_i) test_mem[test_addr_i] <= test_wdata_i;
  end

  assign rd_data_o = pipe_mem[rd_addr_i];
  assign wr_ptr_o  = wr_ptr_q;
endmodule

// File: rtl/tbm_ctrl.sv
`timescale 1ns/1ps
module tbm_ctrl
  import tbm_pkg::*;
#(
  parameter int NUM_BUF    = 4,
  parameter int BUF_DEPTH  = 64,
  parameter int PIPE_DEPTH = 512,
  parameter int OVF_W      = 8,
  localparam int SW        = $clog2(NUM_BUF),
  localparam int BAW       = $clog2(BUF_DEPTH),
  localparam int LEN_W     = $clog2(BUF_DEPTH + 1),
  localparam int PAW       = $clog2(PIPE_DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           lvl1_acc_i,
  input  logic                           lvl2_acc_i,
  input  logic [PAW-1:0]                 pipe_lat_i,
  input  logic [LEN_W-1:0]               win_len_i,
  input  logic [PAW-1:0]                 wr_ptr_i,
  output logic [PAW-1:0]                 pipe_rd_addr_o,
  output logic                           buf_we_o,
  output logic [SW-1:0]                  buf_wslot_o,
  output logic [BAW-1:0]                 buf_waddr_o,
  output logic [NUM_BUF-1:0][LEN_W-1:0]  slot_len_o,
  output logic [NUM_BUF-1:0]             touched_o,
  output logic [NUM_BUF-1:0]             buf_full_o,
  output logic [NUM_BUF-1:0]             buf_free_o,
  output logic                           rel_valid_o,
  output logic [SW-1:0]                  rel_buf_o,
  output logic [OVF_W-1:0]               ovf_cnt_o
);
  slot_state_e      state_q [NUM_BUF];
  logic [PAW-1:0]   start_q [NUM_BUF];
  logic [LEN_W-1:0] len_q   [NUM_BUF];
  logic [NUM_BUF-1:0] touched_q;
  logic [SW-1:0]    alloc_ptr_q, rel_ptr_q, cp_ptr_q;
  logic [BAW-1:0]   cp_cnt_q;
  logic [OVF_W-1:0] ovf_q;
  logic             rel_valid_q;
  logic [SW-1:0]    rel_slot_q;

  logic             copy_act, copy_last, alloc_ok, rel_ok;
  logic [LEN_W-1:0] eff_len;
  logic [PAW-1:0]   new_start;

  always_comb begin
    if (win_len_i == '0 || win_len_i > LEN_W'(BUF_DEPTH)) eff_len = LEN_W'(BUF_DEPTH);
    else                                                   eff_len = win_len_i;
  end

  assign new_start = wr_ptr_i - pipe_lat_i;
  assign copy_act  = (state_q[cp_ptr_q] == SLOT_ARMED);
  assign copy_last = (LEN_W'(cp_cnt_q) == len_q[cp_ptr_q] - LEN_W'(1));
  assign alloc_ok  = lvl1_acc_i && (state_q[alloc_ptr_q] == SLOT_FREE);
  assign rel_ok    = lvl2_acc_i && (state_q[rel_ptr_q] == SLOT_FULL);

  // copy, allocate and release touch distinct slots: ARMED, FREE, FULL
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        state_q[i] <= SLOT_FREE;
        start_q[i] <= '0;
        len_q[i]   <= LEN_W'(BUF_DEPTH);
      end
      touched_q   <= '0;
      alloc_ptr_q <= '0;
      rel_ptr_q   <= '0;
      cp_ptr_q    <= '0;
      cp_cnt_q    <= '0;
      ovf_q       <= '0;
      rel_valid_q <= 1'b0;
      rel_slot_q  <= '0;
    end else begin
      rel_valid_q <= 1'b0;
      if (copy_act) begin
        if (copy_last) begin
          state_q[cp_ptr_q] <= SLOT_FULL;
          cp_cnt_q          <= '0;
          cp_ptr_q          <= cp_ptr_q + SW'(1);
        end else begin
          cp_cnt_q <= cp_cnt_q + BAW'(1);
        end
      end
      if (alloc_ok) begin
        state_q[alloc_ptr_q]   <= SLOT_ARMED;
        start_q[alloc_ptr_q]   <= new_start;
        len_q[alloc_ptr_q]     <= eff_len;
        touched_q[alloc_ptr_q] <= 1'b1;
        alloc_ptr_q            <= alloc_ptr_q + SW'(1);
      end else if (lvl1_acc_i && ovf_q != '1) begin
        ovf_q <= ovf_q + OVF_W'(1);
      end
      if (rel_ok) begin
        state_q[rel_ptr_q] <= SLOT_FREE;
        rel_ptr_q          <= rel_ptr_q + SW'(1);
        rel_valid_q        <= 1'b1;
        rel_slot_q         <= rel_ptr_q;
      end
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    assign buf_full_o[g] = (state_q[g] == SLOT_FULL);
    assign buf_free_o[g] = (state_q[g] == SLOT_FREE);
    assign slot_len_o[g] = len_q[g];
  end

  assign touched_o      = touched_q;
  assign pipe_rd_addr_o = start_q[cp_ptr_q] + PAW'(cp_cnt_q);
  assign buf_we_o       = copy_act;
  assign buf_wslot_o    = cp_ptr_q;
  assign buf_waddr_o    = cp_cnt_q;
  assign rel_valid_o    = rel_valid_q;
  assign rel_buf_o      = rel_slot_q;
  assign ovf_cnt_o      = ovf_q;

  assert_copy_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_act |-> (LEN_W'(cp_cnt_q) < len_q[cp_ptr_q]));

  assert_rr_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok |=> (state_q[$past(alloc_ptr_q)] == SLOT_ARMED));

  assert_release_frees_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_ok |=> (state_q[$past(rel_ptr_q)] == SLOT_FREE) && rel_valid_o);

  assert_no_alloc_on_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl1_acc_i && state_q[alloc_ptr_q] != SLOT_FREE) |=> $stable(alloc_ptr_q));
endmodule

// File: rtl/tbm_bufmem.sv
`timescale 1ns/1ps
module tbm_bufmem
  import tbm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 64,
  localparam int SW       = $clog2(NUM_BUF),
  localparam int BAW      = $clog2(BUF_DEPTH),
  localparam int LEN_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SW-1:0]                 wslot_i,
  input  logic [BAW-1:0]                waddr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_BUF-1:0][LEN_W-1:0] slot_len_i,
  input  logic [NUM_BUF-1:0]            touched_i,
  input  logic [SW-1:0]                 rd_sel_i,
  input  logic                          rd_start_i,
  input  logic                          rd_en_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_empty_o
);
  logic [DATA_W-1:0] mem [NUM_BUF*BUF_DEPTH];
  logic [SW-1:0]     rd_slot_q;
  logic [LEN_W-1:0]  rd_cnt_q;
  logic              rd_active_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[{wslot_i, waddr_i}] <= wdata_i;
  end

  assign rd_empty_o = !rd_active_q || (rd_cnt_q >= slot_len_i[rd_slot_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_slot_q   <= '0;
      rd_cnt_q    <= '0;
      rd_active_q <= 1'b0;
    end else if (rd_start_i) begin
      rd_slot_q   <= rd_sel_i;
      rd_cnt_q    <= '0;
      rd_active_q <= 1'b1;
    end else if (rd_en_i && !rd_empty_o) begin
      rd_cnt_q <= rd_cnt_q + LEN_W'(1);
    end
  end

  always_comb begin
    if (rd_empty_o)               rd_data_o = '0;
    else if (touched_i[rd_slot_q]) rd_data_o = mem[{rd_slot_q, rd_cnt_q[BAW-1:0]}];
    else                          rd_data_o = DATA_W'(dflt_word(32'(rd_slot_q), 32'(rd_cnt_q)));
  end

  assert_empty_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_empty_o && !rd_start_i) |=> $stable(rd_cnt_q));
endmodule

// File: rtl/trig_buf_mgr.sv
`timescale 1ns/1ps
module trig_buf_mgr #(
  parameter int DATA_W     = 16,
  parameter int PIPE_DEPTH = 512,
  parameter int NUM_BUF    = 4,
  parameter int BUF_DEPTH  = 64,
  parameter int OVF_W      = 8,
  localparam int PAW       = $clog2(PIPE_DEPTH),
  localparam int SW        = $clog2(NUM_BUF),
  localparam int BAW       = $clog2(BUF_DEPTH),
  localparam int LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              src_sel_i,
  input  logic              test_we_i,
  input  logic [PAW-1:0]    test_addr_i,
  input  logic [DATA_W-1:0] test_wdata_i,
  input  logic [PAW-1:0]    pipe_lat_i,
  input  logic [LEN_W-1:0]  win_len_i,
  input  logic              lvl1_acc_i,
  input  logic              lvl2_acc_i,
  input  logic [SW-1:0]     rd_sel_i,
  input  logic              rd_start_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o,
  output logic [NUM_BUF-1:0] buf_full_o,
  output logic [NUM_BUF-1:0] buf_free_o,
  output logic              rel_valid_o,
  output logic [SW-1:0]     rel_buf_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);
  logic [PAW-1:0]                 wr_ptr, pipe_rd_addr;
  logic [DATA_W-1:0]              pipe_rd_data;
  logic                           buf_we;
  logic [SW-1:0]                  buf_wslot;
  logic [BAW-1:0]                 buf_waddr;
  logic [NUM_BUF-1:0][LEN_W-1:0]  slot_len;
  logic [NUM_BUF-1:0]             touched;

  tbm_pipe #(.DATA_W(DATA_W), .PIPE_DEPTH(PIPE_DEPTH)) i_pipe (
    .clk_i, .rst_ni, .din_i, .src_sel_i, .test_we_i, .test_addr_i, .test_wdata_i,
    .rd_addr_i (pipe_rd_addr),
    .rd_data_o (pipe_rd_data),
    .wr_ptr_o  (wr_ptr)
  );

  tbm_ctrl #(.NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH), .PIPE_DEPTH(PIPE_DEPTH),
             .OVF_W(OVF_W)) i_ctrl (
    .clk_i, .rst_ni, .lvl1_acc_i, .lvl2_acc_i, .pipe_lat_i, .win_len_i,
    .wr_ptr_i       (wr_ptr),
    .pipe_rd_addr_o (pipe_rd_addr),
    .buf_we_o       (buf_we),
    .buf_wslot_o    (buf_wslot),
    .buf_waddr_o    (buf_waddr),
    .slot_len_o     (slot_len),
    .touched_o      (touched),
    .buf_full_o, .buf_free_o, .rel_valid_o, .rel_buf_o, .ovf_cnt_o
  );

  tbm_bufmem #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH)) i_bufmem (
    .clk_i, .rst_ni,
    .we_i       (buf_we),
    .wslot_i    (buf_wslot),
    .waddr_i    (buf_waddr),
    .wdata_i    (pipe_rd_data),
    .slot_len_i (slot_len),
    .touched_i  (touched),
    .rd_sel_i, .rd_start_i, .rd_en_i, .rd_data_o, .rd_empty_o
  );
endmodule

// File: tb/test_trig_buf_mgr.sv
`timescale 1ns/1ps
module test_trig_buf_mgr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] din_i = '0;
  logic        src_sel_i = 1'b0;
  logic        test_we_i = 1'b0;
  logic [8:0]  test_addr_i = '0;
  logic [15:0] test_wdata_i = '0;
  logic [8:0]  pipe_lat_i = 9'd1;
  logic [6:0]  win_len_i = 7'd1;
  logic        lvl1_acc_i = 1'b0;
  logic        lvl2_acc_i = 1'b0;
  logic [1:0]  rd_sel_i = '0;
  logic        rd_start_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rd_empty_o;
  logic [3:0]  buf_full_o, buf_free_o;
  logic        rel_valid_o;
  logic [1:0]  rel_buf_o;
  logic [7:0]  ovf_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  trig_buf_mgr i_trig_buf_mgr (.*);

  always #2 clk_i = ~clk_i;

  // {lat[8:0], len[6:0]}
  localparam logic [15:0] VECS [4] = '{
    {9'd5,   7'd34},
    {9'd1,   7'd1},
    {9'd200, 7'd64},
    {9'd37,  7'd3}
  };

  // din equals the index of the edge that stores it
  initial begin
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      din_i <= din_i + 16'd1;
    end
  end

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_l1(output int x);
    lvl1_acc_i = 1'b1;
    x = int'(din_i);
    tick();
    lvl1_acc_i = 1'b0;
  endtask

  task automatic release_chk(input int slot, input string req);
    lvl2_acc_i = 1'b1;
    tick();
    lvl2_acc_i = 1'b0;
    chk(req, "rel_valid", 32'(rel_valid_o), 32'd1);
    chk(req, "rel_buf", 32'(rel_buf_o), 32'(slot));
    chk(req, "free bit", 32'(buf_free_o[slot]), 32'd1);
  endtask

  // mode 0: live din, 1: test memory pattern, 2: power-up pattern
  task automatic drain(input int slot, input int base, input int len, input int mode, input string req);
    logic [15:0] exp;
    rd_sel_i   = 2'(slot);
    rd_start_i = 1'b1;
    tick();
    rd_start_i = 1'b0;
    rd_en_i    = 1'b1;
    for (int k = 0; k < len; k++) begin
      case (mode)
        0:       exp = 16'(base + k);
        1:       exp = 16'hC000 | 16'((base + k) & 511);
        default: exp = 16'hD000 | 16'(slot << 8) | 16'(k);
      endcase
      chk(req, $sformatf("slot%0d word%0d", slot, k), 32'(rd_data_o), 32'(exp));
      if (k == 0) chk("R10", "not empty at start", 32'(rd_empty_o), 32'd0);
      tick();
    end
    chk("R10", "empty after len", 32'(rd_empty_o), 32'd1);
    tick();
    chk("R10", "rd_en while empty ignored", 32'(rd_empty_o), 32'd1);
    chk("R10", "data zero while empty", 32'(rd_data_o), 32'd0);
    rd_en_i = 1'b0;
  endtask

  initial begin
    int x;
    int xs [4];
    int xn;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R11", "full after reset", 32'(buf_full_o), 32'h0);
    chk("R11", "free after reset", 32'(buf_free_o), 32'hF);
    chk("R11", "ovf after reset", 32'(ovf_cnt_o), 32'h0);
    chk("R11", "rel_valid after reset", 32'(rel_valid_o), 32'h0);
    chk("R11", "empty after reset", 32'(rd_empty_o), 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    repeat (300) tick();

    // R8: untouched buffer pattern
    drain(2, 0, 64, 2, "R8");

    // table walk: R1 window, R3 allocation and full timing, R5 release
    for (int i = 0; i < 4; i++) begin
      int lat, len;
      lat = int'(VECS[i][15:7]);
      len = int'(VECS[i][6:0]);
      pipe_lat_i = 9'(lat);
      win_len_i  = 7'(len);
      pulse_l1(x);
      repeat (len - 1) tick();
      chk("R3", $sformatf("vec%0d full not yet", i), 32'(buf_full_o[i]), 32'd0);
      tick();
      chk("R3", $sformatf("vec%0d full", i), 32'(buf_full_o[i]), 32'd1);
      drain(i, x - lat, len, 0, "R1");
      release_chk(i, "R5");
    end

    // R4: back-to-back accepts, R7: fifth one overflows
    pipe_lat_i = 9'd10;
    win_len_i  = 7'd20;
    for (int k = 0; k < 4; k++) begin
      lvl1_acc_i = 1'b1;
      xs[k] = int'(din_i);
      tick();
    end
    tick();
    lvl1_acc_i = 1'b0;
    chk("R7", "overflow count", 32'(ovf_cnt_o), 32'd1);
    repeat (90) tick();
    chk("R4", "all full", 32'(buf_full_o), 32'hF);
    chk("R7", "overflow count stable", 32'(ovf_cnt_o), 32'd1);
    for (int k = 0; k < 4; k++) drain(k, xs[k] - 10, 20, 0, "R4");

    // R6: reuse on the clock after release
    lvl2_acc_i = 1'b1;
    tick();
    lvl2_acc_i = 1'b0;
    chk("R5", "fifo release 0", 32'(rel_buf_o), 32'd0);
    chk("R5", "rel_valid", 32'(rel_valid_o), 32'd1);
    win_len_i  = 7'd5;
    lvl1_acc_i = 1'b1;
    xn = int'(din_i);
    tick();
    lvl1_acc_i = 1'b0;
    chk("R6", "slot0 claimed", 32'(buf_free_o[0]), 32'd0);
    chk("R6", "no overflow", 32'(ovf_cnt_o), 32'd1);
    repeat (6) tick();
    chk("R6", "slot0 refilled", 32'(buf_full_o[0]), 32'd1);
    release_chk(1, "R5");
    release_chk(2, "R5");
    release_chk(3, "R5");
    drain(0, xn - 10, 5, 0, "R6");
    release_chk(0, "R5");
    lvl2_acc_i = 1'b1;
    tick();
    lvl2_acc_i = 1'b0;
    chk("R5", "ignored with none full", 32'(rel_valid_o), 32'd0);
    chk("R5", "all still free", 32'(buf_free_o), 32'hF);

    // R2: zero length means 64
    pipe_lat_i = 9'd3;
    win_len_i  = 7'd0;
    pulse_l1(x);
    repeat (70) tick();
    chk("R2", "slot1 full", 32'(buf_full_o[1]), 32'd1);
    drain(1, x - 3, 64, 0, "R2");
    release_chk(1, "R5");

    // R9: test memory as source
    test_we_i = 1'b1;
    for (int a = 0; a < 512; a++) begin
      test_addr_i  = 9'(a);
      test_wdata_i = 16'hC000 | 16'(a);
      tick();
    end
    test_we_i = 1'b0;
    src_sel_i = 1'b1;
    repeat (520) tick();
    pipe_lat_i = 9'd4;
    win_len_i  = 7'd8;
    pulse_l1(x);
    repeat (10) tick();
    drain(2, x - 4, 8, 1, "R9");
    src_sel_i = 1'b0;
    release_chk(2, "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule